// File: doc/BRIEF.md
# Pipelined Integer Divider

This block divides a numerator by a denominator and returns a quotient and a remainder. The two operands have separate widths: the quotient takes the numerator width and the remainder takes the denominator width. Each operand can be read as unsigned or as two's complement, and that choice is made for each operand on its own. By default the quotient rounds toward zero and the remainder carries the sign of the numerator. A second remainder mode forces the remainder to be non-negative and corrects the quotient to match.

Internally the block works on magnitudes with a restoring divider that produces one quotient bit per step. The latency parameter places zero or more register stages across those steps. At zero the path is purely combinational. At any other value there are exactly that many stages, which share one clock enable and one synchronous active-high clear. A skip parameter tells the block how many leading quotient bits are known to be zero, and the steps for those bits are left out. Elaboration stops with an error when the latency is larger than the numerator width, or when the skip count is not smaller than it. A zero denominator gives a fixed result.

Top module: `pipe_divider`

## Requirements
- R1: With both operands unsigned and the default remainder mode, the quotient is the integer quotient and the remainder is the integer remainder, so that num = quo*den + rem.
- R2: When NUM_SIGNED=1 the numerator is read as two's complement, and when DEN_SIGNED=1 the denominator is read that way. In the default mode the quotient truncates toward zero and a non-zero remainder has the sign of the numerator.
- R3: With REM_MODE=REM_NONNEG and a non-zero denominator, the remainder satisfies 0 <= rem < |den|. The quotient is corrected so that num = quo*den + rem still holds.
- R4: When the denominator is zero, the quotient is all ones. The remainder is the numerator resized to WD bits: sign-extended if the numerator is signed, zero-extended if it is not, and truncated if the numerator is wider than WD.
- R5: Results that do not fit their port wrap modulo 2^width. For example, with both operands signed, the most negative numerator divided by -1 gives the most negative value.
- R6: With LAT=0 the outputs are a combinational function of the present inputs.
- R7: With LAT=L>0, an operand pair captured at an enabled clock edge produces its result after exactly L enabled edges. A new pair can be accepted at every enabled edge.
- R8: While ce is low, no stage advances and both outputs hold their values.
- R9: A clock edge with clr high sets every stage register to zero, whatever ce is. Until real data reaches the output again, the output reads as a divide of zero by zero: quotient all ones, remainder zero.
- R10: With SKIP=S, the result is the same as with SKIP=0 for any operands whose quotient magnitude is below 2^(WN-S). A zero denominator still returns the all-ones quotient.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the stage registers |
| clr | input | 1 | Synchronous active-high clear of all stages |
| ce | input | 1 | Clock enable; low stalls every stage |
| num | input | WN | Numerator |
| den | input | WD | Denominator |
| quo | output | WN | Quotient |
| rem | output | WD | Remainder |

## Verification
The bench builds six copies of the block side by side, all fed from one shared operand stream:

- every numerator/denominator signedness pairing;
- both remainder modes;
- latencies of 0, 1, 2, 3 and the full numerator width;
- a denominator narrower than the numerator, and one wider;
- a skip count of three.

The full-width copy places one quotient step in each stage. This exposes skew between the operand side information and the partial results as they move together through the stages. The two-stage skip copy splits its five steps unevenly, and its operands are shaped so the known-zero guarantee holds. A stream of one new pair per cycle, random stalls and mid-run clears bring into reach in-flight ordering, stage hold, and refilling from the cleared state.

// File: rtl/div_pkg.sv
package div_pkg;

    // Remainder sign convention.
    typedef enum logic {
        REM_TRUNC  = 1'b0,   // remainder follows the numerator sign
        REM_NONNEG = 1'b1    // remainder never negative
    } rem_mode_e;

    // Number of quotient steps assigned to segment idx when total steps
    // are spread over segs segments; earlier segments take the extra ones.
    function automatic int seg_iters(input int total, input int segs, input int idx);
        int base;
        int extra;
        base  = total / segs;
        extra = total % segs;
        return base + ((idx < extra) ? 1 : 0);
    endfunction

endpackage

// File: rtl/div_prep.sv
module div_prep #(
    parameter int WN         = 16,
    parameter int WD         = 16,
    parameter bit NUM_SIGNED = 1'b0,
    parameter bit DEN_SIGNED = 1'b0,
    parameter int SKIP       = 0
) (
    input  logic [WN-1:0] num_i,
    input  logic [WD-1:0] den_i,
    output logic [WD-1:0] part_o,
    output logic [WN-1:0] nq_o,
    output logic [WD-1:0] dm_o,
    output logic          nneg_o,
    output logic          dneg_o
);
    localparam int ITER = WN - SKIP;

    logic [WN-1:0] nm;

    always_comb begin
        nneg_o = NUM_SIGNED & num_i[WN-1];
        dneg_o = DEN_SIGNED & den_i[WD-1];
        nm     = nneg_o ? -num_i : num_i;
        dm_o   = dneg_o ? -den_i : den_i;
        // Bits of the skipped steps seed the partial remainder directly.
        part_o = WD'(nm >> ITER);
        nq_o   = nm << SKIP;
    end

    // Only the most negative signed numerator keeps its top magnitude bit.
    always_comb begin
        if (NUM_SIGNED && nm[WN-1]) begin
            a_r2_magnitude_range: assert (num_i == (WN'(1) << (WN-1)))
                else $error("numerator magnitude out of range");
        end
    end

endmodule

// File: rtl/div_iter.sv
module div_iter #(
    parameter int WN    = 16,
    parameter int WD    = 16,
    parameter int ITERS = 1
) (
    input  logic [WD-1:0] part_i,
    input  logic [WN-1:0] nq_i,
    input  logic [WD-1:0] dm_i,
    output logic [WD-1:0] part_o,
    output logic [WN-1:0] nq_o
);
    // Restoring steps: shift one numerator bit into the partial remainder,
    // subtract the divisor when it fits, shift the quotient bit in below.
    logic [WD:0]   wide;
    logic [WD-1:0] p;
    logic [WN-1:0] nq;
    logic          qb;

    always_comb begin
        wide = '0;
        qb   = 1'b0;
        p    = part_i;
        nq   = nq_i;
        for (int k = 0; k < ITERS; k++) begin
            wide = {p, nq[WN-1]};
            if (wide >= {1'b0, dm_i}) begin
                wide = wide - {1'b0, dm_i};
                qb   = 1'b1;
            end else begin
                qb   = 1'b0;
            end
            p  = wide[WD-1:0];
            nq = (nq << 1) | WN'(qb);
        end
        part_o = p;
        nq_o   = nq;
    end

    // A partial remainder below the divisor stays below it (R1 datapath).
    always_comb begin
        if (dm_i != '0 && part_i < dm_i) begin
            a_r1_partial_below_den: assert (part_o < dm_i)
                else $error("partial remainder escaped divisor bound");
        end
    end

endmodule

// File: rtl/div_fix.sv
module div_fix
    import div_pkg::*;
#(
    parameter int        WN       = 16,
    parameter int        WD       = 16,
    parameter rem_mode_e REM_MODE = REM_TRUNC
) (
    input  logic [WD-1:0] part_i,
    input  logic [WN-1:0] nq_i,
    input  logic [WD-1:0] dm_i,
    input  logic          nneg_i,
    input  logic          dneg_i,
    output logic [WN-1:0] quo_o,
    output logic [WD-1:0] rem_o
);
    logic [WN-1:0] qm2;
    logic [WD-1:0] rm2;
    logic          rsign;
    logic          qneg;

    always_comb begin
        qneg  = nneg_i ^ dneg_i;
        qm2   = nq_i;
        rm2   = part_i;
        rsign = nneg_i;
        if (REM_MODE == REM_NONNEG && nneg_i && part_i != '0) begin
            qm2   = nq_i + WN'(1);
            rm2   = dm_i - part_i;
            rsign = 1'b0;
        end
        quo_o = qneg ? -qm2 : qm2;
        rem_o = rsign ? -rm2 : rm2;
        if (dm_i == '0) begin
            quo_o = '1;
            rem_o = nneg_i ? -part_i : part_i;
        end
    end

    always_comb begin
        if (REM_MODE == REM_NONNEG && dm_i != '0 && part_i < dm_i) begin
            a_r3_rem_bound: assert (rem_o < dm_i)
                else $error("non-negative remainder not below divisor");
        end
    end

endmodule

// File: rtl/pipe_divider.sv
module pipe_divider
    import div_pkg::*;
#(
    parameter int        WN         = 16,
    parameter int        WD         = 16,
    parameter bit        NUM_SIGNED = 1'b0,
    parameter bit        DEN_SIGNED = 1'b0,
    parameter rem_mode_e REM_MODE   = REM_TRUNC,
    parameter int        LAT        = 0,
    parameter int        SKIP       = 0
) (
    input  logic          clk,
    input  logic          clr,
    input  logic          ce,
    input  logic [WN-1:0] num,
    input  logic [WD-1:0] den,
    output logic [WN-1:0] quo,
    output logic [WD-1:0] rem
);
    localparam int ITER = WN - SKIP;
    localparam int NSEG = (LAT == 0) ? 1 : LAT;

    if (LAT < 0 || LAT > WN) begin : g_lat_chk
        $error("LAT must lie between 0 and WN");
    end
    if (SKIP < 0 || SKIP >= WN) begin : g_skip_chk
        $error("SKIP must be below WN");
    end

    typedef struct packed {
        logic [WD-1:0] part;
        logic [WN-1:0] nq;
        logic [WD-1:0] dm;
        logic          nneg;
        logic          dneg;
    } seg_t;

    logic [WD-1:0] p0, d0;
    logic [WN-1:0] q0;
    logic          sn0, sd0;
    seg_t          st0;

    div_prep #(
        .WN(WN), .WD(WD), .NUM_SIGNED(NUM_SIGNED), .DEN_SIGNED(DEN_SIGNED), .SKIP(SKIP)
    ) u_prep (
        .num_i(num), .den_i(den), .part_o(p0), .nq_o(q0),
        .dm_o(d0), .nneg_o(sn0), .dneg_o(sd0)
    );

    assign st0 = '{part: p0, nq: q0, dm: d0, nneg: sn0, dneg: sd0};

    for (genvar s = 0; s < NSEG; s++) begin : g_seg
        seg_t          in_s;
        seg_t          nx_s;
        seg_t          out_s;
        logic [WD-1:0] p_nx;
        logic [WN-1:0] q_nx;

        if (s == 0) begin : g_first
            assign in_s = st0;
        end else begin : g_next
            assign in_s = g_seg[s-1].out_s;
        end

        div_iter #(
            .WN(WN), .WD(WD), .ITERS(seg_iters(ITER, NSEG, s))
        ) u_it (
            .part_i(in_s.part), .nq_i(in_s.nq), .dm_i(in_s.dm),
            .part_o(p_nx), .nq_o(q_nx)
        );

        assign nx_s = '{part: p_nx, nq: q_nx, dm: in_s.dm, nneg: in_s.nneg, dneg: in_s.dneg};

        if (LAT > 0) begin : g_reg
            always_ff @(posedge clk) begin
                if (clr) begin
                    out_s <= '0;
                end else if (ce) begin
                    out_s <= nx_s;
                end
            end
        end else begin : g_comb
            assign out_s = nx_s;
        end
    end

    seg_t fin;
    assign fin = g_seg[NSEG-1].out_s;

    div_fix #(
        .WN(WN), .WD(WD), .REM_MODE(REM_MODE)
    ) u_fix (
        .part_i(fin.part), .nq_i(fin.nq), .dm_i(fin.dm),
        .nneg_i(fin.nneg), .dneg_i(fin.dneg), .quo_o(quo), .rem_o(rem)
    );

    a_r8_stall_hold: assert property (@(posedge clk) disable iff (clr)
        (LAT > 0 && !ce) |=> ($stable(quo) && $stable(rem)))
        else $error("outputs moved during stall");

    a_r9_clear_state: assert property (@(posedge clk)
        (LAT > 0 && clr) |=> (quo == '1 && rem == '0))
        else $error("clear did not empty the stages");

endmodule

// File: tb/sim_pipe_divider.sv
module sim_pipe_divider;
    import div_pkg::*;

    logic clk = 1'b0;
    always #4 clk = ~clk;   // 125 MHz

    logic       clr, ce;
    logic [7:0] n, d, n5;
    logic [7:0] q0, r0, q1, r1, q2, r2, q3, q5, r4;
    logic [5:0] r3, q4;
    logic [3:0] r5;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;
    logic [15:0] hist [0:8191];
    int  k     = 0;
    int  clr_k = 0;
    bit  stalled;

    // Keeps the quotient of the skip instance below 2^5.
    function automatic logic [7:0] skipfix(input logic [7:0] nn, input logic [7:0] dd);
        int dv;
        dv = int'(dd[3:0]);
        if (dv == 0) return nn;
        return 8'(int'(nn) % (dv * 32));
    endfunction

    assign n5 = skipfix(n, d);

    pipe_divider #(.WN(8), .WD(8), .NUM_SIGNED(0), .DEN_SIGNED(0), .REM_MODE(REM_TRUNC),  .LAT(0), .SKIP(0))
        u0 (.clk(clk), .clr(clr), .ce(ce), .num(n),      .den(d),      .quo(q0), .rem(r0));
    pipe_divider #(.WN(8), .WD(8), .NUM_SIGNED(1), .DEN_SIGNED(1), .REM_MODE(REM_TRUNC),  .LAT(1), .SKIP(0))
        u1 (.clk(clk), .clr(clr), .ce(ce), .num(n),      .den(d),      .quo(q1), .rem(r1));
    pipe_divider #(.WN(8), .WD(8), .NUM_SIGNED(1), .DEN_SIGNED(0), .REM_MODE(REM_NONNEG), .LAT(8), .SKIP(0))
        u2 (.clk(clk), .clr(clr), .ce(ce), .num(n),      .den(d),      .quo(q2), .rem(r2));
    pipe_divider #(.WN(8), .WD(6), .NUM_SIGNED(0), .DEN_SIGNED(1), .REM_MODE(REM_NONNEG), .LAT(3), .SKIP(0))
        u3 (.clk(clk), .clr(clr), .ce(ce), .num(n),      .den(d[5:0]), .quo(q3), .rem(r3));
    pipe_divider #(.WN(6), .WD(8), .NUM_SIGNED(1), .DEN_SIGNED(1), .REM_MODE(REM_NONNEG), .LAT(0), .SKIP(0))
        u4 (.clk(clk), .clr(clr), .ce(ce), .num(n[5:0]), .den(d),      .quo(q4), .rem(r4));
    pipe_divider #(.WN(8), .WD(4), .NUM_SIGNED(0), .DEN_SIGNED(0), .REM_MODE(REM_TRUNC),  .LAT(2), .SKIP(3))
        u5 (.clk(clk), .clr(clr), .ce(ce), .num(n5),     .den(d[3:0]), .quo(q5), .rem(r5));

    task automatic cfg(input int i, output int wn, output int wd, output int lat,
                       output bit ns, output bit ds, output bit pos, output string tag);
        case (i)
            0: begin wn = 8; wd = 8; lat = 0; ns = 0; ds = 0; pos = 0; tag = "R1";  end
            1: begin wn = 8; wd = 8; lat = 1; ns = 1; ds = 1; pos = 0; tag = "R2";  end
            2: begin wn = 8; wd = 8; lat = 8; ns = 1; ds = 0; pos = 1; tag = "R7";  end
            3: begin wn = 8; wd = 6; lat = 3; ns = 0; ds = 1; pos = 1; tag = "R3";  end
            4: begin wn = 6; wd = 8; lat = 0; ns = 1; ds = 1; pos = 1; tag = "R6";  end
            default: begin wn = 8; wd = 4; lat = 2; ns = 0; ds = 0; pos = 0; tag = "R10"; end
        endcase
    endtask

    function automatic longint wmask(input int w);
        return (longint'(1) << w) - 1;
    endfunction

    function automatic longint sval(input logic [7:0] raw, input int w, input bit sg);
        longint v;
        v = longint'(raw) & wmask(w);
        if (sg && ((v >> (w - 1)) & 1) == 1) v = v - (longint'(1) << w);
        return v;
    endfunction

    task automatic model(input logic [7:0] nr, input logic [7:0] dr, input int wn, input int wd,
                         input bit ns, input bit ds, input bit pos,
                         output longint q, output longint r);
        longint nv, dv;
        nv = sval(nr, wn, ns);
        dv = sval(dr, wd, ds);
        if (dv == 0) begin
            q = wmask(wn);
            r = nv & wmask(wd);
        end else begin
            q = nv / dv;
            r = nv % dv;
            if (pos && r < 0) begin
                if (dv > 0) begin q = q - 1; r = r + dv; end
                else        begin q = q + 1; r = r - dv; end
            end
            q = q & wmask(wn);
            r = r & wmask(wd);
        end
    endtask

    task automatic check_all();
        for (int i = 0; i < 6; i++) begin
            int wn, wd, lat;
            bit ns, ds, pos, zero;
            string tag;
            logic [7:0] en, ed;
            longint eq, er, gq, gr;
            cfg(i, wn, wd, lat, ns, ds, pos, tag);
            zero = 1'b0;
            en = n; ed = d;
            if (lat > 0) begin
                if (k - lat >= clr_k) {en, ed} = hist[k - lat + 1];
                else zero = 1'b1;
            end
            if (i == 5) en = skipfix(en, ed);
            case (i)
                0: begin gq = longint'(q0); gr = longint'(r0); end
                1: begin gq = longint'(q1); gr = longint'(r1); end
                2: begin gq = longint'(q2); gr = longint'(r2); end
                3: begin gq = longint'(q3); gr = longint'(r3); end
                4: begin gq = longint'(q4); gr = longint'(r4); end
                default: begin gq = longint'(q5); gr = longint'(r5); end
            endcase
            if (zero) begin
                eq = wmask(wn); er = 0; tag = "R9";     // cleared stages read as 0/0
            end else begin
                model(en, ed, wn, wd, ns, ds, pos, eq, er);
                if ((longint'(ed) & wmask(wd)) == 0) tag = "R4";
                else if (i == 1 && en == 8'h80 && ed == 8'hFF) tag = "R5";
                else if (stalled && lat > 0) tag = "R8";
            end
            total++;
            if (gq != eq || gr != er) begin
                bad++;
                $display("FAIL %s u%0d num=%h den=%h: actual q=%h r=%h expected q=%h r=%h",
                         tag, i, en, ed, gq, gr, eq, er);
            end
        end
    endtask

    function automatic logic [15:0] directed(input int idx);
        case (idx)
            0:  return 16'h80FF;  1:  return 16'h7F01;  2:  return 16'h0000;  3:  return 16'h8500;
            4:  return 16'hFFFF;  5:  return 16'h8001;  6:  return 16'h640F;  7:  return 16'h9C0F;
            8:  return 16'h9CF1;  9:  return 16'h0703;  10: return 16'hF903;  11: return 16'h07FD;
            12: return 16'hF9FD;  13: return 16'h0180;  14: return 16'hFF01;  default: return 16'h0005;
        endcase
    endfunction

    initial begin
        int unsigned seed;
        seed = 32'd5150;
        void'($urandom(seed));
        clr = 1'b1; ce = 1'b0; n = '0; d = '0;
        for (int c = 0; c < 4000; c++) begin
            @(negedge clk);
            if (clr) clr_k = k;
            else if (ce) begin k++; hist[k] = {n, d}; end
            stalled = !clr && !ce;
            check_all();
            clr = (c < 1) || (c == 2000) || (c == 2600);
            if (c < 1000)                     ce = 1'b1;
            else if (c >= 1500 && c < 1506)   ce = 1'b0;
            else if (c == 2600)               ce = 1'b0;
            else                              ce = ($urandom % 4) != 0;
            if (c >= 1 && c < 17) begin
                {n, d} = directed(c - 1);
            end else begin
                n = 8'($urandom);
                d = 8'($urandom);
                if ($urandom % 16 == 0) d = '0;
            end
        end
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL R7 watchdog: actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule